// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the cycle-level front end of a synchronous burst SRAM core. On every rising clock edge it looks at three chip-enable inputs, two address strobes, a burst advance input and the write controls. It sorts the cycle into one of four kinds: deselect, burst begin, burst continue or burst suspend. It also marks the cycle as a read or a write. It tells the separate burst address block whether to load the external address or step to the next one, and it raises one write strobe per byte lane of the memory array.

Read data comes back from the array on `rd_word`. The block hands it to the data pins in one of two ways, chosen by the static input `pipe_mode`. In pipelined mode the data goes through a rising-edge output register. In flow-through mode it goes straight through, one cycle earlier. A tri-state enable, `dq_oe`, tells the pad when to drive. The asynchronous active-low output enable `oe_n` can force that enable off at any moment.

The two strobes are not treated alike. The processor-side strobe is masked by the primary enable. The controller-side strobe turns a disabled chip into a deselect. A read issued while `oe_n` is high, called a dummy read, lets the bus turn around from reads to writes without spending a deselect cycle.

Top module: `sburst_ctrl`

## Requirements
- R1: While `e1_n` is high, `adsp_n` has no effect. A cycle with `e1_n` high and `adsc_n` low is a deselect. A cycle with `e1_n` high, `adsc_n` high and `adsp_n` low is classified purely by `adv_n`.
- R2: In a cycle where a strobe is taken, `e2` low or `e3_n` high makes the cycle a deselect. A taken strobe is `adsp_n` low with `e1_n` low, or `adsc_n` low. When no strobe is taken, `e2` and `e3_n` are ignored.
- R3: A taken strobe with the chip enabled is a burst begin (`cyc_kind` = 1) and asserts `addr_load`. A begin taken through `adsp_n` is always a read. A begin taken through `adsc_n` alone is a read or a write according to the write inputs.
- R4: With no strobe taken, `adv_n` low gives a continue (`cyc_kind` = 2) and asserts `addr_adv`. `adv_n` high gives a suspend (`cyc_kind` = 3), which asserts neither `addr_load` nor `addr_adv`. In both cases the write inputs decide read or write. Deselect is `cyc_kind` = 0.
- R5: In a non-deselect write cycle, `gw_n` low raises every bit of `wr_be`, whatever `bw_n` and `be_n` are.
- R6: When `gw_n` is high:
  - `bw_n` low makes the cycle a write, and each bit of `wr_be` is the inverse of the matching `be_n` bit. This includes the case with no bytes selected.
  - `bw_n` high makes the cycle a read.
- R7: `wr_be` is all zero in deselect cycles and in read cycles.
- R8: `dq_oe` stays low for the data slot of every write and every deselect cycle. In the data slot of a read cycle it covers all byte lanes, whatever `be_n` shows.
- R9: With `pipe_mode` high, the data slot of the command sampled at edge k is the cycle after edge k+1. During that slot `dq_out` holds the `rd_word` value that was present just before edge k+1.
- R10: With `pipe_mode` low, the data slot of the command sampled at edge k is the cycle after edge k. During that slot `dq_out` follows `rd_word`.
- R11: `oe_n` high forces `dq_oe` low at once, without waiting for a clock. `oe_n` low raises `dq_oe` only during the data slot of a read.
- R12: A read issued while `oe_n` is high is classified and sequenced exactly like any other read. A write may follow it directly with no deselect in between.
- R13: A deselect turns the drivers off one clock later in pipelined mode and immediately in flow-through mode. After reset, `dq_oe` is low in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_mode | input | 1 | 1 = registered read path, 0 = flow-through (static) |
| e1_n | input | 1 | Primary chip enable, active low |
| e2 | input | 1 | Secondary chip enable, active high |
| e3_n | input | 1 | Secondary chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write-all override, active low |
| bw_n | input | 1 | Byte write enable, active low |
| be_n | input | BYTES | Per-byte write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_word | input | DATA_W | Array word at the current burst address |
| addr_load | output | 1 | Load the external address this cycle |
| addr_adv | output | 1 | Step the burst address this cycle |
| cyc_kind | output | 2 | 0 deselect, 1 begin, 2 continue, 3 suspend |
| cyc_write | output | 1 | Cycle is a write |
| wr_be | output | BYTES | Per-byte array write strobes |
| dq_out | output | DATA_W | Read data toward the pads |
| dq_oe | output | 1 | Pad driver enable |

## Verification
The checker assumes that `pipe_mode` changes only while reset is held. It also assumes that every control input is settled before each rising edge. It does not assume that `oe_n` is synchronous; it relies only on the output enable being gated by `oe_n`. The stimulus sets every input half a period before the edge that samples it. It switches between the two read modes only inside a reset. Its random phase mixes every strobe, enable and write combination, so it also produces the masked and contradictory cases that the fixed sequences cover by name.

// File: rtl/sbc_pkg.sv
// Shared types for the burst SRAM cycle controller.
package sbc_pkg;
    // Cycle classification; the encoding is visible on the top-level port.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_BEGIN = 2'd1,
        CYC_NEXT  = 2'd2,
        CYC_HOLD  = 2'd3
    } cyc_kind_t;
endpackage

// File: rtl/sbc_cmd_decode.sv
// Cycle classifier. Sorts the sampled control inputs into deselect, begin,
// continue or suspend, and into read or write.
// Assumes: wr_req already merges the write-all and byte-write controls.
module sbc_cmd_decode
    import sbc_pkg::*;
(
    input  logic      e1_n,
    input  logic      e2,
    input  logic      e3_n,
    input  logic      adsp_n,
    input  logic      adsc_n,
    input  logic      adv_n,
    input  logic      wr_req,
    output cyc_kind_t kind,
    output logic      is_write
);
    logic p_take;
    logic c_take;
    logic chip_on;

    // Strobe acceptance: the primary enable masks only the processor strobe.
    always_comb begin
        p_take  = !adsp_n && !e1_n;
        c_take  = !adsc_n;
        chip_on = !e1_n && e2 && !e3_n;
    end

    // Classification; a processor-strobe begin always reads.
    always_comb begin
        if ((p_take || c_take) && !chip_on) begin
            kind     = CYC_IDLE;
            is_write = 1'b0;
        end else if (p_take) begin
            kind     = CYC_BEGIN;
            is_write = 1'b0;
        end else if (c_take) begin
            kind     = CYC_BEGIN;
            is_write = wr_req;
        end else if (!adv_n) begin
            kind     = CYC_NEXT;
            is_write = wr_req;
        end else begin
            kind     = CYC_HOLD;
            is_write = wr_req;
        end
    end
endmodule

// File: rtl/sbc_byte_strobe.sv
// Per-byte write strobe generator.
// Assumes: cmd_write is already qualified by the cycle classification.
module sbc_byte_strobe #(
    parameter int BYTES = 4
) (
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [BYTES-1:0] be_n,
    input  logic             cmd_write,
    output logic             wr_req,
    output logic [BYTES-1:0] wr_be
);
    // Raw write request, before classification.
    always_comb wr_req = !gw_n || !bw_n;

    // One strobe per lane; the write-all override wins over the lane selects.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        always_comb wr_be[b] = cmd_write && (!gw_n || (!bw_n && !be_n[b]));
    end
endmodule

// File: rtl/sbc_read_path.sv
// Read return path with selectable latency and gated driver enable.
// Assumes: pipe_mode is static outside reset; oe_n is asynchronous.
module sbc_read_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              rd_cmd,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic              rd_q;
    logic              rd_q2;
    logic [DATA_W-1:0] dout_q;

    // First stage: a read was commanded at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_cmd;
    end

    // Output register stage, used only in pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q2  <= 1'b0;
            dout_q <= '0;
        end else begin
            rd_q2  <= rd_q;
            dout_q <= rd_word;
        end
    end

    // Mode select and asynchronous gating of the driver enable.
    always_comb begin
        dq_out = pipe_mode ? dout_q : rd_word;
        dq_oe  = (pipe_mode ? rd_q2 : rd_q) && !oe_n;
    end
endmodule

// File: rtl/sburst_ctrl.sv
// Synchronous burst SRAM cycle controller: classifies each clock cycle,
// drives the address-sequencer controls and byte write strobes, and returns
// read data with registered or flow-through latency.
// Assumes: the burst address block and the array sit outside; rd_word is the
// array word at the address chosen by the last edge.
module sburst_ctrl
    import sbc_pkg::*;
#(
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8,
    localparam int DATA_W = BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              e1_n,
    input  logic              e2,
    input  logic              e3_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bw_n,
    input  logic [BYTES-1:0]  be_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] rd_word,
    output logic              addr_load,
    output logic              addr_adv,
    output logic [1:0]        cyc_kind,
    output logic              cyc_write,
    output logic [BYTES-1:0]  wr_be,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    cyc_kind_t kind;
    logic      wr_req;
    logic      rd_cmd;

    sbc_cmd_decode i_dec (
        .e1_n    (e1_n),
        .e2      (e2),
        .e3_n    (e3_n),
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .adv_n   (adv_n),
        .wr_req  (wr_req),
        .kind    (kind),
        .is_write(cyc_write)
    );

    sbc_byte_strobe #(.BYTES(BYTES)) i_stb (
        .gw_n     (gw_n),
        .bw_n     (bw_n),
        .be_n     (be_n),
        .cmd_write(cyc_write),
        .wr_req   (wr_req),
        .wr_be    (wr_be)
    );

    // Sequencer controls and read command derived from the classification.
    always_comb begin
        cyc_kind  = kind;
        addr_load = (kind == CYC_BEGIN);
        addr_adv  = (kind == CYC_NEXT);
        rd_cmd    = (kind != CYC_IDLE) && !cyc_write;
    end

    sbc_read_path #(.DATA_W(DATA_W)) i_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pipe_mode(pipe_mode),
        .rd_cmd   (rd_cmd),
        .oe_n     (oe_n),
        .rd_word  (rd_word),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );
endmodule

// File: rtl/sbc_checker.sv
// Property checker for sburst_ctrl, attached by bind.
// Assumes: pipe_mode only changes while rst_n is low.
module sbc_checker #(
    parameter int BYTES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pipe_mode,
    input logic             e1_n,
    input logic             e2,
    input logic             e3_n,
    input logic             adsp_n,
    input logic             adsc_n,
    input logic             gw_n,
    input logic             oe_n,
    input logic             addr_load,
    input logic [1:0]       cyc_kind,
    input logic             cyc_write,
    input logic [BYTES-1:0] wr_be,
    input logic             dq_oe
);
    AST_E1_MASKS_ADSC: assert property (@(posedge clk) disable iff (!rst_n)
        (e1_n && !adsc_n) |-> (cyc_kind == 2'd0)); // R1
    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!adsc_n || (!adsp_n && !e1_n)) && (!e2 || e3_n)) |-> (cyc_kind == 2'd0)); // R2
    AST_ADSP_BEGIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!e1_n && !adsp_n && e2 && !e3_n) |-> (addr_load && !cyc_write)); // R3
    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_write && cyc_kind != 2'd0 && !gw_n) |-> (&wr_be)); // R5
    AST_NO_STROBE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'd0 || !cyc_write) |-> (wr_be == '0)); // R7
    AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R11
    AST_FT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && $past(cyc_write || cyc_kind == 2'd0)) |-> !dq_oe); // R10
    AST_PIPE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(cyc_write || cyc_kind == 2'd0, 2)) |-> !dq_oe); // R9
endmodule

bind sburst_ctrl sbc_checker #(.BYTES(BYTES)) i_sbc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pipe_mode(pipe_mode),
    .e1_n     (e1_n),
    .e2       (e2),
    .e3_n     (e3_n),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .gw_n     (gw_n),
    .oe_n     (oe_n),
    .addr_load(addr_load),
    .cyc_kind (cyc_kind),
    .cyc_write(cyc_write),
    .wr_be    (wr_be),
    .dq_oe    (dq_oe)
);

// File: tb/test_sburst_ctrl.sv
module test_sburst_ctrl;
    localparam int BYTES = 4;
    localparam int DW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pipe_mode = 1'b1;
    logic e1_n, e2, e3_n, adsp_n, adsc_n, adv_n, gw_n, bw_n, oe_n;
    logic [BYTES-1:0] be_n;
    logic [DW-1:0] rd_word;
    logic addr_load, addr_adv, cyc_write, dq_oe;
    logic [1:0] cyc_kind;
    logic [BYTES-1:0] wr_be;
    logic [DW-1:0] dq_out;

    // Environment: external address, write data, array and burst counter.
    logic [3:0]    ext_addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] mem [16];
    logic [3:0]    cur;
    logic [3:0]    opa;

    int compared = 0;
    int mismatched = 0;
    bit last_read;
    logic [DW-1:0] last_data;

    always #2.5 clk = ~clk;

    sburst_ctrl i_sburst_ctrl (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
        .e1_n(e1_n), .e2(e2), .e3_n(e3_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n), .oe_n(oe_n),
        .rd_word(rd_word), .addr_load(addr_load), .addr_adv(addr_adv),
        .cyc_kind(cyc_kind), .cyc_write(cyc_write), .wr_be(wr_be),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always_comb begin
        if (addr_load)     opa = ext_addr;
        else if (addr_adv) opa = {cur[3:2], cur[1:0] + 2'd1};
        else               opa = cur;
        rd_word = mem[cur];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= 32'hA500_0000 ^ (i * 32'h0103_0507);
        end else begin
            cur <= opa;
            for (int b = 0; b < BYTES; b++)
                if (wr_be[b]) mem[opa][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_idle();
        e1_n = 1; e2 = 1; e3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
        gw_n = 1; bw_n = 1; be_n = '1; oe_n = 0; ext_addr = 0; wdata = 0;
    endtask

    // Reference classification: kind 0..3 and write flag.
    task automatic ref_dec(output int k, output bit w);
        bit wr_any = !gw_n || !bw_n;
        bit on = !e1_n && e2 && !e3_n;
        if (!e1_n && !adsp_n) begin
            k = on ? 1 : 0; w = 0;
        end else if (!adsc_n) begin
            k = on ? 1 : 0; w = on && wr_any;
        end else begin
            k = adv_n ? 3 : 2; w = wr_any;
        end
    endtask

    // One clock: inputs already set at a falling edge.
    task automatic tick(string req);
        int k; bit w; bit rd; bit exp_oe;
        logic [BYTES-1:0] exp_be;
        logic [DW-1:0] exp_d;
        ref_dec(k, w);
        exp_be = (k != 0 && w) ? (!gw_n ? '1 : ~be_n) : '0;
        rd = (k != 0) && !w;
        #1;
        check({req, " kind (R1 R2 R3 R4)"}, cyc_kind, k);
        check({req, " write (R3 R4 R6)"}, cyc_write, (k != 0) && w);
        check({req, " strobes (R5 R6 R7)"}, wr_be, exp_be);
        check({req, " load/adv (R3 R4)"}, {addr_load, addr_adv}, {k == 1, k == 2});
        @(posedge clk);
        @(negedge clk);
        if (pipe_mode) begin
            exp_oe = last_read && !oe_n; exp_d = last_data;
        end else begin
            exp_oe = rd && !oe_n; exp_d = mem[cur];
        end
        check({req, " drive (R8 R9 R10 R11 R13)"}, dq_oe, exp_oe);
        if (exp_oe) check({req, " data (R9 R10)"}, dq_out, exp_d);
        last_read = rd;
        last_data = mem[cur];
    endtask

    task automatic do_reset(bit p);
        rst_n = 0; pipe_mode = p; set_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1; last_read = 0; last_data = 0;
        check("reset drive off R13", dq_oe, 0);
    endtask

    task automatic directed();
        // R3 R5: controller-strobe begin, write all lanes at address 4.
        set_idle(); e1_n = 0; adsc_n = 0; gw_n = 0; ext_addr = 4; wdata = 32'h1122_3344;
        tick("R5 begin write-all");
        // R6: continue write lanes 0 and 2 only.
        set_idle(); adv_n = 0; bw_n = 0; be_n = 4'b1010; wdata = 32'hAABB_CCDD;
        tick("R6 lane write");
        // R6: byte write with no lane selected.
        set_idle(); bw_n = 0;
        tick("R6 empty write");
        // R3: processor-strobe begin with write-all low is still a read.
        set_idle(); e1_n = 0; adsp_n = 0; gw_n = 0; ext_addr = 4;
        tick("R3 adsp read");
        // R4: four continues wrap inside the 4-word block, then suspend.
        for (int i = 0; i < 4; i++) begin
            set_idle(); adv_n = 0; tick("R4 continue read");
        end
        set_idle(); tick("R4 suspend read");
        // R1: processor strobe masked by e1_n.
        set_idle(); adsp_n = 0; adv_n = 0; e2 = 0; tick("R1 masked adsp");
        set_idle(); adsc_n = 0; ext_addr = 2; tick("R1 e1 high deselect");
        set_idle(); tick("R13 after deselect");
        // R2: secondary enables during a strobe.
        set_idle(); e1_n = 0; adsc_n = 0; e2 = 0; tick("R2 e2 low");
        set_idle(); e1_n = 0; adsp_n = 0; e3_n = 1; tick("R2 e3 high");
        // R12: dummy read then write without a deselect, then read back.
        set_idle(); e1_n = 0; adsc_n = 0; ext_addr = 8; oe_n = 1; tick("R12 dummy read");
        set_idle(); adv_n = 0; gw_n = 0; wdata = 32'hCAFE_F00D; oe_n = 1; tick("R12 turnaround write");
        set_idle(); e1_n = 0; adsc_n = 0; ext_addr = 9; tick("R12 read back");
        set_idle(); tick("R11 suspend read");
        set_idle(); oe_n = 1; tick("R11 oe high");
        set_idle(); e1_n = 0; adsc_n = 0; e2 = 0; tick("R13 deselect");
        set_idle(); tick("R13 deselect tail");
    endtask

    task automatic random_run(int n);
        for (int i = 0; i < n; i++) begin
            e1_n = ($urandom % 4) == 0; e2 = ($urandom % 6) != 0; e3_n = ($urandom % 6) == 0;
            adsp_n = ($urandom % 3) != 0; adsc_n = ($urandom % 3) != 0; adv_n = $urandom;
            gw_n = ($urandom % 4) != 0; bw_n = $urandom; be_n = $urandom;
            oe_n = ($urandom % 5) == 0; ext_addr = $urandom; wdata = $urandom;
            tick("random");
        end
    endtask

    initial begin
        set_idle();
        do_reset(1);
        directed();
        random_run(400);
        do_reset(0);
        directed();
        random_run(400);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5 * 150000);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule